// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog with a compact register window on a simple peripheral bus. It runs on the bus clock. Software arms it once. A down-counter then runs from a period picked by a 4-bit range field. Software keeps the system alive by writing one exact key value to the restart register. Any other value is ignored, so a runaway write cannot feed the dog by accident.

If the counter runs out, the block drives a system reset pulse whose length software picks. In the interrupt-first mode it raises an interrupt on the first expiry and reloads. It resets the system only if a second expiry arrives before the interrupt is handled. The live count, a status bit and identification words can be read at any time.

Bus transfers take two cycles: a setup cycle with `psel` high and `penable` low, then an access cycle with both high. Read data is captured in the setup cycle and presented during the access cycle.

Top module: `wdt_keyed`

## Requirements
- R1: After a synchronous reset, the block is in its idle state:
  - control (0x00), timeout range (0x04) and status (0x10) read 0;
  - `irq` and `sys_rst` are low;
  - the count register (0x08) reads 2^BASE_EXP-1.
- R2: Control bit 0 is the run bit. Writing 1 sets it. A later write with bit 0 clear leaves it set; only reset clears it.
- R3: While running, the counter steps down by one each clock. From 0 it reloads to 2^(BASE_EXP+n)-1, where n is the range field (bits 3:0 of 0x04). A read of 0x08 returns the live count as it stood in the setup cycle.
- R4: A write of exactly 0x00000076 to 0x0C reloads the counter. Any other value written there leaves the countdown undisturbed.
- R5: Rewriting the range field while the counter is running does not change the current countdown. The new period is used from the next restart or expiry reload.
- R6: When control bit 1 is 0, an expiry (counter at 0 while running) starts a `sys_rst` pulse. The pulse is high for exactly 2^(c+1) clocks, where c is control bits 4:2 (code 7 gives 256 clocks). An expiry that arrives while a pulse is already high is ignored.
- R7: When control bit 1 is 1, the first expiry sets status bit 0 and raises `irq`, and the counter reloads. A further expiry while status is still set starts the `sys_rst` pulse.
- R8: The status bit and `irq` are cleared either by a read of 0x14, which returns 0, or by a valid key write to 0x0C. If an expiry sets status in the same cycle, the set takes priority.
- R9: The read-only words are:
  - 0xFC returns the type parameter;
  - 0xF8 returns the version parameter;
  - 0xF4 returns {BASE_EXP[15:0], pulse-code width[7:0], range width[7:0]}.

  Writes to these words are ignored. Any other unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset in the 256-byte window |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt from the first expiry in interrupt-first mode |
| sys_rst | output | 1 | System reset pulse |

## Verification
The hardest state to reach is a second expiry in interrupt-first mode while status is still pending. Reaching it needs two full periods with no key write and no acknowledge read. The same stimulus must also avoid an expiry landing inside a reset pulse that is already running. The bench shrinks the base exponent so that periods are a few dozen clocks. It then simply idles across two periods after raising the interrupt. It also overlaps a 256-clock pulse with a 32-clock period to hit the ignored-trigger case. A behavioural model predicts count, status, `irq`, `sys_rst` and every read value on each clock.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_RANGE = 8'h04;
  localparam logic [7:0] OFF_COUNT = 8'h08;
  localparam logic [7:0] OFF_KICK  = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_ACK   = 8'h14;
  localparam logic [7:0] OFF_PARAM = 8'hF4;
  localparam logic [7:0] OFF_VER   = 8'hF8;
  localparam logic [7:0] OFF_TYPE  = 8'hFC;

  localparam logic [7:0] KICK_KEY  = 8'h76;
  localparam int         PLEN_W    = 3;

  typedef struct packed {
    logic [PLEN_W-1:0] plen;
    logic              irq_first;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TOP_W    = 4,
  parameter int CNT_W    = 31,
  parameter int BASE_EXP = 16,
  parameter logic [31:0] ID_TYPE = 32'h5744_0001,
  parameter logic [31:0] ID_VER  = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic [TOP_W-1:0]  top_o,
  output logic              restart_o,
  output logic              stat_o,
  output logic [DATA_W-1:0] prdata_o
);
  logic wr_acc, rd_acc, rd_setup, ack_rd;
  ctrl_t ctrl_q;
  logic [TOP_W-1:0] top_q;
  logic stat_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_acc    = psel && penable && pwrite;
    rd_acc    = psel && penable && !pwrite;
    rd_setup  = psel && !penable && !pwrite;
    restart_o = wr_acc && (paddr == ADDR_W'(OFF_KICK)) && (pwdata == DATA_W'(KICK_KEY));
    ack_rd    = rd_acc && (paddr == ADDR_W'(OFF_ACK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      top_q  <= '0;
    end else if (wr_acc) begin
      if (paddr == ADDR_W'(OFF_CTRL)) begin
        ctrl_q.run       <= ctrl_q.run | pwdata[0];
        ctrl_q.irq_first <= pwdata[1];
        ctrl_q.plen      <= pwdata[2 +: PLEN_W];
      end
      if (paddr == ADDR_W'(OFF_RANGE)) top_q <= pwdata[TOP_W-1:0];
    end
  end

  // status: an expiry that sets wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) stat_q <= 1'b0;
    else if (expire_i && ctrl_q.irq_first && !stat_q) stat_q <= 1'b1;
    else if (restart_o || ack_rd) stat_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (paddr)
      ADDR_W'(OFF_CTRL):  rd_mux = DATA_W'(ctrl_q);
      ADDR_W'(OFF_RANGE): rd_mux = DATA_W'(top_q);
      ADDR_W'(OFF_COUNT): rd_mux = DATA_W'(cnt_i);
      ADDR_W'(OFF_STAT):  rd_mux = DATA_W'(stat_q);
      ADDR_W'(OFF_PARAM): rd_mux = DATA_W'({16'(BASE_EXP), 8'(PLEN_W), 8'(TOP_W)});
      ADDR_W'(OFF_VER):   rd_mux = DATA_W'(ID_VER);
      ADDR_W'(OFF_TYPE):  rd_mux = DATA_W'(ID_TYPE);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prdata_o <= '0;
    else if (rd_setup) prdata_o <= rd_mux;
  end

  assign ctrl_o = ctrl_q;
  assign top_o  = top_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/wdt_keyed_count.sv
module wdt_keyed_count #(
  parameter int TOP_W    = 4,
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [TOP_W-1:0] top_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'((64'd1 << BASE_EXP) - 64'd1);

  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt_q;

  // the range field is sampled only when a load happens
  always_comb begin
    span     = (CNT_W+1)'(1) << (BASE_EXP + int'(top_i));
    reload   = span[CNT_W-1:0] - CNT_W'(1);
    expire_o = run_i && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= RST_CNT;
    else if (!run_i || restart_i || expire_o) cnt_q <= reload;
    else cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_keyed_pulse.sv
module wdt_keyed_pulse #(
  parameter int PLEN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              pulse_o
);
  localparam int PW = 1 << PLEN_W;

  logic [PW:0]   span;
  logic [PW-1:0] left_q;
  logic          pulse_q;

  always_comb span = (PW+1)'(2) << plen_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (trig_i && !pulse_q) begin
      pulse_q <= 1'b1;
      left_q  <= PW'(span - (PW+1)'(1));
    end else if (pulse_q) begin
      if (left_q == '0) pulse_q <= 1'b0;
      else left_q <= left_q - PW'(1);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TOP_W    = 4,
  parameter int BASE_EXP = 16,
  parameter logic [31:0] ID_TYPE = 32'h5744_0001,
  parameter logic [31:0] ID_VER  = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              sys_rst
);
  localparam int CNT_W = BASE_EXP + (1 << TOP_W) - 1;

  ctrl_t            ctrl_w;
  logic [TOP_W-1:0] top_w;
  logic             restart_w;
  logic             stat_w;
  logic [CNT_W-1:0] cnt_w;
  logic             expire_w;
  logic             trig_w;

  wdt_keyed_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_W(TOP_W), .CNT_W(CNT_W),
    .BASE_EXP(BASE_EXP), .ID_TYPE(ID_TYPE), .ID_VER(ID_VER)
  ) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cnt_i(cnt_w), .expire_i(expire_w),
    .ctrl_o(ctrl_w), .top_o(top_w), .restart_o(restart_w), .stat_o(stat_w),
    .prdata_o(prdata)
  );

  wdt_keyed_count #(.TOP_W(TOP_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run_i(ctrl_w.run), .top_i(top_w),
    .restart_i(restart_w), .cnt_o(cnt_w), .expire_o(expire_w)
  );

  // direct mode resets at once; interrupt-first mode only with status pending
  assign trig_w = expire_w && (!ctrl_w.irq_first || stat_w);

  wdt_keyed_pulse #(.PLEN_W(PLEN_W)) u_pulse (
    .clk(clk), .rst(rst), .trig_i(trig_w), .plen_i(ctrl_w.plen), .pulse_o(sys_rst)
  );

  assign irq = stat_w;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31,
  parameter int PLEN_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              run,
  input logic              irq_first,
  input logic [PLEN_W-1:0] plen,
  input logic [CNT_W-1:0]  cnt,
  input logic              restart,
  input logic              expire,
  input logic              irq,
  input logic              sys_rst
);
  localparam int RUN_W = (1 << PLEN_W) + 2;

  logic [RUN_W-1:0]  run_len;
  logic [PLEN_W-1:0] plen_cap;
  logic bad_key, ack;

  assign bad_key = psel && penable && pwrite && (paddr == ADDR_W'(8'h0C)) && (pwdata != DATA_W'(8'h76));
  assign ack     = psel && penable && !pwrite && (paddr == ADDR_W'(8'h14));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len  <= '0;
      plen_cap <= '0;
    end else begin
      run_len <= sys_rst ? run_len + RUN_W'(1) : '0;
      if (!sys_rst) plen_cap <= plen;
    end
  end

  assert_run_sticky_R2: assert property (@(posedge clk) disable iff (rst) run |=> run);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !expire && !restart) |=> (cnt == $past(cnt) - CNT_W'(1)));
  assert_bad_key_R4: assert property (@(posedge clk) disable iff (rst)
    (bad_key && run && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (run_len == (RUN_W'(2) << plen_cap)));
  assert_irq_mode_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(irq_first));
  assert_second_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && irq_first && irq && !sys_rst) |=> sys_rst);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && !expire) |=> !irq);
endmodule

bind wdt_keyed wdt_keyed_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PLEN_W(wdt_keyed_pkg::PLEN_W)
) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .run(ctrl_w.run), .irq_first(ctrl_w.irq_first),
  .plen(ctrl_w.plen), .cnt(cnt_w), .restart(restart_w), .expire(expire_w),
  .irq(irq), .sys_rst(sys_rst)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  localparam int B = 2;
  localparam logic [31:0] TYPE_ID = 32'h5744_0001;
  localparam logic [31:0] VER_ID  = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic irq, sys_rst;

  always #2 clk = ~clk;

  wdt_keyed #(.BASE_EXP(B), .ID_TYPE(TYPE_ID), .ID_VER(VER_ID)) u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .sys_rst(sys_rst)
  );

  int n_chk = 0, n_fail = 0;
  string rd_tag = "R1";
  bit done = 0;

  // behavioural reference
  bit m_en, m_mode, m_stat, m_rst, m_rdv;
  int m_code, m_top, m_rem;
  longint m_cnt, m_prd;

  function automatic longint reload_of(int top);
    return (longint'(1) << (B + top)) - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_mode = 0; m_code = 0; m_top = 0; m_stat = 0;
      m_cnt = reload_of(0); m_rst = 0; m_rem = 0; m_prd = 0; m_rdv = 0;
    end else begin
      bit wr, rdacc, setup, expire, kick, ack, trig;
      longint nxt;
      wr = psel && penable && pwrite;
      rdacc = psel && penable && !pwrite;
      setup = psel && !penable && !pwrite;
      expire = m_en && (m_cnt == 0);
      kick = wr && paddr == 8'h0C && pwdata == 32'h76;
      ack = rdacc && paddr == 8'h14;
      trig = expire && (!m_mode || m_stat);
      m_rdv = setup;
      if (setup) begin
        case (paddr)
          8'h00: m_prd = (m_code << 2) | (int'(m_mode) << 1) | int'(m_en);
          8'h04: m_prd = m_top;
          8'h08: m_prd = m_cnt;
          8'h10: m_prd = m_stat;
          8'hF4: m_prd = (longint'(B) << 16) | (3 << 8) | 4;
          8'hF8: m_prd = VER_ID;
          8'hFC: m_prd = TYPE_ID;
          default: m_prd = 0;
        endcase
      end
      if (!m_en || kick || expire) nxt = reload_of(m_top);
      else nxt = m_cnt - 1;
      if (trig && !m_rst) begin m_rst = 1; m_rem = (2 << m_code) - 1; end
      else if (m_rst) begin if (m_rem == 0) m_rst = 0; else m_rem--; end
      if (expire && m_mode && !m_stat) m_stat = 1;
      else if (kick || ack) m_stat = 0;
      m_cnt = nxt;
      if (wr && paddr == 8'h00) begin
        m_en = m_en | pwdata[0]; m_mode = pwdata[1]; m_code = int'(pwdata[4:2]);
      end
      if (wr && paddr == 8'h04) m_top = int'(pwdata[3:0]);
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 irq", longint'(irq), longint'(m_stat));
      chk("R6 sys_rst", longint'(sys_rst), longint'(m_rst));
      if (m_rdv) chk({rd_tag, " prdata"}, longint'(prdata), m_prd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); rd_tag = tag; psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(4); rst = 0;
    // R1 reset state, R9 identification
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h10, "R1");
    rd(8'hFC, "R9"); rd(8'hF8, "R9"); rd(8'hF4, "R9"); rd(8'hE4, "R9"); rd(8'h40, "R9");
    chk("R1 irq low", longint'(irq), 0);
    chk("R1 sys_rst low", longint'(sys_rst), 0);
    wr(8'hFC, 32'hDEAD_BEEF); rd(8'hFC, "R9");
    // R3 run with period 64
    wr(8'h04, 32'h4); rd(8'h04, "R3");
    wr(8'h00, 32'h5);
    rd(8'h08, "R3"); rd(8'h08, "R3"); idle(5); rd(8'h08, "R3");
    // R2 run bit sticky
    wr(8'h00, 32'h4); rd(8'h00, "R2");
    // R4 wrong keys
    wr(8'h0C, 32'h77); rd(8'h08, "R4");
    wr(8'h0C, 32'h176); rd(8'h08, "R4");
    wr(8'h0C, 32'h7600); rd(8'h08, "R4");
    wr(8'h0C, 32'h76); rd(8'h08, "R4");
    // R5 range change applies at next load
    wr(8'h04, 32'h1); rd(8'h08, "R5"); rd(8'h08, "R5");
    wr(8'h0C, 32'h76); rd(8'h08, "R5"); rd(8'h08, "R5");
    // R6 direct-mode pulses, period 8, length 4
    idle(40);
    wr(8'h04, 32'h3); wr(8'h0C, 32'h76);
    wr(8'h00, 32'h1D); // code 7, 256-clock pulse, period 32
    idle(600);
    // R7/R8 interrupt-first mode, period 128
    wr(8'h04, 32'h5); wr(8'h00, 32'h7); wr(8'h0C, 32'h76);
    idle(140);
    chk("R7 irq after first expiry", longint'(irq), 1);
    rd(8'h10, "R8"); rd(8'h14, "R8"); rd(8'h10, "R8");
    chk("R8 irq cleared by ack", longint'(irq), 0);
    idle(140);
    idle(140);
    wr(8'h0C, 32'h76); rd(8'h10, "R8");
    chk("R8 irq cleared by key", longint'(irq), 0);
    idle(10);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule